// File: doc/BRIEF.md
# Early Branch Redirect Controller

This block sits in the front end of a five-stage in-order pipeline: fetch, address computation, operand fetch, operate, and store. It owns the program counter and the valid bits of the stages after fetch. When an unconditional branch is recognised early in the pipe, it loads the branch target into the program counter in the same cycle. It does not wait for the branch to drain to the store stage.

Two stages can redirect fetch:

- **Address computation stage.** A direct jump takes its target from the computed effective address.
- **Operand fetch stage.** An indirect jump takes its target from the operand value just read from a register or from memory.

On a redirect, only the forwarding stage and the stages younger than it are turned into bubbles. Older instructions keep flowing.

Skip instructions are supported. A skip decides in the operate stage whether to annul the instruction that follows it. A direct jump in address computation is not forwarded while a skip sits directly ahead of it in operand fetch. Instead the jump moves on and carries its target with it. It then forwards from operand fetch in the cycle the skip resolves as not taken. If the skip is taken, the jump is annulled and never redirects.

Top module: `fwd_ctl`

## Requirements
- R1: While reset is asserted, the PC equals the `RESET_PC` parameter and all four stage valid outputs are 0. After reset is released, the stages fill one per cycle: address computation first, then operand fetch, operate and store.
- R2: When the address computation stage holds a valid direct jump (`ac_jmp`=1), `redir` is 1 and `redir_of` is 0 in that cycle. At the next edge, `pc` takes the value of `ac_ea`.
- R3: When the operand fetch stage holds a valid indirect jump (`of_jind`=1), `redir` and `redir_of` are both 1 in that cycle. At the next edge, `pc` takes the value of `of_opnd`.
- R4: If both stages want to redirect in the same cycle, the operand fetch stage wins: `redir_of`=1 and `pc` takes `of_opnd`.
- R5: A redirect clears, at the next edge, the valid bit of every stage from fetch up to and including the forwarding stage.
  - A redirect from address computation leaves address computation and operand fetch invalid.
  - A redirect from operand fetch leaves address computation, operand fetch and operate invalid.
- R6: A redirect does not touch the instructions that are older than the forwarding stage. They advance one stage per cycle as usual.
- R7: A direct jump in address computation is not forwarded while a valid skip instruction (`ac_skip` was 1 when it was in address computation) occupies operand fetch. The jump then advances to operand fetch with its effective address. In the next cycle it redirects from operand fetch to that address, provided the skip in operate resolves as not taken (`skip_take`=0).
- R8: A valid skip in operate with `skip_take`=1 annuls the instruction in operand fetch:
  - No redirect comes from that instruction, even if it is a jump.
  - The operate stage is invalid at the next edge.
- R9: In any cycle without a redirect, `pc` increments by one at the edge.
- R10: Jump flags on an invalid address computation stage are ignored. `skip_take` is ignored when the operate stage does not hold a valid skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ac_jmp | input | 1 | Address computation stage decodes a direct unconditional jump |
| ac_ea | input | AW | Effective address computed in address computation |
| ac_skip | input | 1 | Address computation stage decodes a skip instruction |
| of_jind | input | 1 | Operand fetch stage decodes an indirect unconditional jump |
| of_opnd | input | AW | Operand value read in operand fetch |
| skip_take | input | 1 | Condition of the skip in operate is true |
| pc | output | AW | Fetch address |
| redir | output | 1 | Fetch is redirected this cycle |
| redir_of | output | 1 | The redirect comes from operand fetch |
| ac_vld | output | 1 | Address computation stage holds a live instruction |
| of_vld | output | 1 | Operand fetch stage holds a live instruction |
| op_vld | output | 1 | Operate stage holds a live instruction |
| os_vld | output | 1 | Store stage holds a live instruction |

## Verification
The bench targets four situations:

- **Same-cycle priority.** Both stages jump in the same cycle. A design that lets the younger stage win would fetch from the effective address instead of the operand.
- **Flush range.** The bench checks the valid pattern after each redirect. A design that flushes the whole pipe would drop the older instructions in operate and store. One that forgets the forwarding stage itself would let the jump run on down the pipe.
- **Skip hold-off.** A design without the hold-off would redirect from address computation past an unresolved skip. A design that drops the held target would never redirect from operand fetch.
- **Taken skip.** A taken skip must annul both a held jump and an indirect jump. The bench also sends a stray `skip_take` and jump flags on a bubble. A design that trusts them would annul a live instruction or jump when it should not.

// File: rtl/fwd_ctl.sv
module fwd_ctl #(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ac_jmp,
  input  logic [AW-1:0] ac_ea,
  input  logic          ac_skip,
  input  logic          of_jind,
  input  logic [AW-1:0] of_opnd,
  input  logic          skip_take,
  output logic [AW-1:0] pc,
  output logic          redir,
  output logic          redir_of,
  output logic          ac_vld,
  output logic          of_vld,
  output logic          op_vld,
  output logic          os_vld
);

  logic          of_skip_q, op_skip_q, of_held_q;
  logic [AW-1:0] of_tgt_q;
  logic          annul, hold_ac, fwd_ac, fwd_of;
  logic [AW-1:0] of_tgt, next_tgt;

  assign annul    = op_vld & op_skip_q & skip_take;
  assign hold_ac  = of_vld & of_skip_q;
  assign fwd_of   = of_vld & (of_jind | of_held_q) & ~annul;
  assign fwd_ac   = ac_vld & ac_jmp & ~hold_ac;
  assign of_tgt   = of_held_q ? of_tgt_q : of_opnd;
  assign next_tgt = fwd_of ? of_tgt : ac_ea;
  assign redir    = fwd_of | fwd_ac;
  assign redir_of = fwd_of;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= RESET_PC;
      ac_vld    <= 1'b0;
      of_vld    <= 1'b0;
      op_vld    <= 1'b0;
      os_vld    <= 1'b0;
      of_skip_q <= 1'b0;
      op_skip_q <= 1'b0;
      of_held_q <= 1'b0;
      of_tgt_q  <= '0;
    end else begin
      pc        <= redir ? next_tgt : pc + AW'(1);
      ac_vld    <= ~redir;
      of_vld    <= ac_vld & ~redir;
      op_vld    <= of_vld & ~fwd_of & ~annul;
      os_vld    <= op_vld;
      of_skip_q <= ac_vld & ac_skip;
      op_skip_q <= of_skip_q;
      of_held_q <= ac_vld & ac_jmp & hold_ac;
      of_tgt_q  <= ac_ea;
    end
  end

endmodule

// File: rtl/fwd_ctl_chk.sv
module fwd_ctl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ac_jmp,
  input logic          of_jind,
  input logic          skip_take,
  input logic [AW-1:0] pc,
  input logic          redir,
  input logic          redir_of,
  input logic          ac_vld,
  input logic          of_vld,
  input logic          op_vld,
  input logic          os_vld,
  input logic          of_skip_q,
  input logic          op_skip_q
);

  AST_FLUSH_AC: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> (!ac_vld && !of_vld)) else $error("flush range"); // R5

  AST_FLUSH_OF: assert property (@(posedge clk) disable iff (!rst_n)
    (redir && redir_of) |=> !op_vld) else $error("of flush"); // R5

  AST_OLDER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (redir && !redir_of && of_vld && !(op_vld && op_skip_q && skip_take)) |=> op_vld)
    else $error("older lost"); // R6

  AST_STORE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |=> os_vld) else $error("store lost"); // R6

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !redir |=> pc == $past(pc) + AW'(1)) else $error("pc step"); // R9

  AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (of_vld && of_skip_q) |-> !(redir && !redir_of)) else $error("hold"); // R7

  AST_PRIO_OF: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_vld && ac_jmp && of_vld && of_jind && !(op_vld && op_skip_q && skip_take)) |-> redir_of)
    else $error("prio"); // R4

  AST_ANNUL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_skip_q && skip_take) |-> !redir_of) else $error("annul"); // R8

endmodule

bind fwd_ctl fwd_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ac_jmp(ac_jmp), .of_jind(of_jind),
  .skip_take(skip_take), .pc(pc), .redir(redir), .redir_of(redir_of),
  .ac_vld(ac_vld), .of_vld(of_vld), .op_vld(op_vld), .os_vld(os_vld),
  .of_skip_q(of_skip_q), .op_skip_q(op_skip_q)
);

// File: tb/sim_fwd_ctl.sv
`timescale 1ns/100ps
module sim_fwd_ctl;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ac_jmp = 0, ac_skip = 0, of_jind = 0, skip_take = 0;
  logic [AW-1:0] ac_ea = '0, of_opnd = '0;
  logic [AW-1:0] pc;
  logic redir, redir_of, ac_vld, of_vld, op_vld, os_vld;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [AW-1:0] pc;
    logic [3:0]    v;
    logic          rd;
    logic          so;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  fwd_ctl #(.AW(AW), .RESET_PC(16'h0100)) u0 (
    .clk(clk), .rst_n(rst_n), .ac_jmp(ac_jmp), .ac_ea(ac_ea), .ac_skip(ac_skip),
    .of_jind(of_jind), .of_opnd(of_opnd), .skip_take(skip_take), .pc(pc),
    .redir(redir), .redir_of(redir_of), .ac_vld(ac_vld), .of_vld(of_vld),
    .op_vld(op_vld), .os_vld(os_vld)
  );

  task automatic cyc(input logic aj, input logic [AW-1:0] ea, input logic ask,
                     input logic oj, input logic [AW-1:0] opn, input logic st,
                     input logic [AW-1:0] epc, input logic [3:0] ev,
                     input logic erd, input logic eso, input string tag);
    exp_t e;
    @(negedge clk);
    ac_jmp = aj; ac_ea = ea; ac_skip = ask;
    of_jind = oj; of_opnd = opn; skip_take = st;
    e.pc = epc; e.v = ev; e.rd = erd; e.so = eso; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    #2;
    if (sb.size() != 0) begin
      exp_t e;
      logic [3:0] v;
      e = sb.pop_front();
      v = {ac_vld, of_vld, op_vld, os_vld};
      checks++;
      if (pc !== e.pc || v !== e.v || redir !== e.rd || (e.rd && redir_of !== e.so)) begin
        errors++;
        $display("FAIL %s: pc=%h v=%b redir=%b of=%b expected pc=%h v=%b redir=%b of=%b",
                 e.tag, pc, v, redir, redir_of, e.pc, e.v, e.rd, e.so);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state and fill
    cyc(0,16'h0,0,0,16'h0,0, 16'h0100,4'b0000,0,0,"R1 reset");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0101,4'b1000,0,0,"R1 fill ac");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0102,4'b1100,0,0,"R1 fill of");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0103,4'b1110,0,0,"R1 fill op");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0104,4'b1111,0,0,"R9 sequential");
    // R2 direct jump from address computation
    cyc(1,16'h0200,0,0,16'h0,0, 16'h0105,4'b1111,1,0,"R2 ac redirect");
    // R10 jump on bubble ignored; R6 older stages continue
    cyc(1,16'h0999,0,0,16'h0,0, 16'h0200,4'b0011,0,0,"R10 R6 ac flush");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0201,4'b1001,0,0,"R5 of flushed");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0202,4'b1100,0,0,"R9 refill");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0203,4'b1110,0,0,"R9 refill");
    // R3 indirect jump from operand fetch
    cyc(0,16'h0,0,1,16'h0300,0, 16'h0204,4'b1111,1,1,"R3 of redirect");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0300,4'b0001,0,0,"R5 R6 of flush");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0301,4'b1000,0,0,"R9 refill");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0302,4'b1100,0,0,"R9 refill");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0303,4'b1110,0,0,"R9 refill");
    // R4 both stages at once
    cyc(1,16'h0400,0,1,16'h0500,0, 16'h0304,4'b1111,1,1,"R4 priority");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0500,4'b0001,0,0,"R4 target");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0501,4'b1000,0,0,"R9 refill");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0502,4'b1100,0,0,"R9 refill");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0503,4'b1110,0,0,"R9 refill");
    // R7 skip hold-off, skip not taken
    cyc(0,16'h0,1,0,16'h0,0, 16'h0504,4'b1111,0,0,"R7 skip enters");
    cyc(1,16'h0600,0,0,16'h0,0, 16'h0505,4'b1111,0,0,"R7 held");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0506,4'b1111,1,1,"R7 retry from of");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0600,4'b0001,0,0,"R7 carried target");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0601,4'b1000,0,0,"R9 refill");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0602,4'b1100,0,0,"R9 refill");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0603,4'b1110,0,0,"R9 refill");
    // R8 skip taken annuls held jump
    cyc(0,16'h0,1,0,16'h0,0, 16'h0604,4'b1111,0,0,"R8 skip enters");
    cyc(1,16'h0700,0,0,16'h0,0, 16'h0605,4'b1111,0,0,"R7 held again");
    cyc(0,16'h0,0,0,16'h0,1, 16'h0606,4'b1111,0,0,"R8 held jump annulled");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0607,4'b1101,0,0,"R8 op bubble");
    cyc(0,16'h0,0,0,16'h0,0, 16'h0608,4'b1110,0,0,"R8 continue");
    // R8 skip taken annuls indirect jump
    cyc(0,16'h0,1,0,16'h0,0, 16'h0609,4'b1111,0,0,"R8 skip enters");
    cyc(0,16'h0,0,0,16'h0,0, 16'h060a,4'b1111,0,0,"R8 skip in of");
    cyc(0,16'h0,0,1,16'h0800,1, 16'h060b,4'b1111,0,0,"R8 indirect annulled");
    cyc(0,16'h0,0,0,16'h0,0, 16'h060c,4'b1101,0,0,"R8 op bubble");
    // R10 stray skip_take ignored
    cyc(0,16'h0,0,0,16'h0,1, 16'h060d,4'b1110,0,0,"R10 stray take");
    cyc(0,16'h0,0,0,16'h0,0, 16'h060e,4'b1111,0,0,"R10 op kept");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule